// File: doc/BRIEF.md
# Mode Register Command Timing Guard

This block sits on the command path between a DDR SDRAM controller's scheduler and the memory command bus. The scheduler offers one command at a time with a valid/ready handshake. The guard accepts a command only when doing so keeps the rules around mode register programming. On the cycle after it accepts a command, it puts that command on a registered bus. In every other cycle it drives a no-operation.

The guard keeps a bitmap with one bit per bank, showing which banks are open. It also runs two down-counters. The precharge counter holds back a mode register write until the precharge period has elapsed. The lockout counter blocks every command after a mode register write. That lockout lasts the programmed mode-write gap, or the long DLL lock wait when a base mode register write asks for a DLL reset. If both apply, the longer of the two governs. Both delays are configuration inputs counted in clock cycles.

Top module: `mrs_timing_guard`

## Requirements
- R1: After reset the bus carries no-operation (code 0) with bank and mode at zero, every bank is idle, and no wait is running, so a mode register write is accepted at once.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, PRECHARGE-ALL=5, MRS=6, EMRS=7. A command accepted at a clock edge (valid and ready both high) appears on the bus with its bank and mode value after that edge. Otherwise the bus shows NOP with zero bank and mode.
- R3: An accepted ACTIVATE marks its bank open. An accepted PRECHARGE closes its bank, and an accepted PRECHARGE-ALL closes every bank. While any bank is open, ready is low for MRS and EMRS.
- R4: If a PRECHARGE or PRECHARGE-ALL is accepted at edge k, no MRS or EMRS is accepted before edge k+tRP. Commands other than mode writes are not held back by this wait.
- R5: If an MRS or EMRS is accepted at edge k, no command of any kind is accepted before edge k+tMRD, and the bus carries NOP throughout.
- R6: If an MRS is accepted at edge k with mode bit 8 set (DLL reset), no command is accepted before edge k+max(200, tMRD). The first command may be accepted exactly at that edge.
- R7: Mode bit 8 on an EMRS has no effect on timing: only the tMRD gap applies.
- R8: A tRP or tMRD configuration value of 0 behaves as 1.
- R9: Ready does not depend on valid. A command offered with valid low changes no state: an ACTIVATE with valid low leaves every bank idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_trp | input | CNT_W | Precharge-to-mode-write delay in cycles |
| cfg_tmrd | input | CNT_W | Mode-write-to-next-command delay in cycles |
| req_valid | input | 1 | Scheduler offers a command |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | BANK_W | Offered bank address |
| req_mode | input | MODE_W | Mode register value carried with MRS/EMRS |
| req_ready | output | 1 | Offered command may be accepted this cycle |
| bus_cmd | output | 3 | Registered command to the memory |
| bus_bank | output | BANK_W | Registered bank address |
| bus_mode | output | MODE_W | Registered mode value |

## Verification
A bank bitmap that is wrong shows up at once as a mode write being refused, or accepted, in the very cycle it is offered. A lockout counter loaded with the wrong length is revealed by the exact edge at which the first command after a mode write is accepted. The checks therefore measure that edge precisely: for the plain tMRD gap, for the 200-cycle DLL wait, and for a tMRD longer than that wait. A counter that underflows or never clears leaves ready low, which the bus shows as a NOP stream that never ends.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_EMRS = 3'd7
  } cmd_e;

  // true for both base and extended mode register writes
  function automatic logic f_is_mode(input cmd_e c);
    return (c == CMD_MRS) || (c == CMD_EMRS);
  endfunction

  function automatic logic f_is_precharge(input cmd_e c);
    return (c == CMD_PRE) || (c == CMD_PREA);
  endfunction

  // a wait of n cycles is a counter preload of n-1; zero counts as one
  function automatic int unsigned f_wait_load(input int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // lockout after a mode write: the longer of tMRD and the DLL wait
  function automatic int unsigned f_lock_cycles(input int unsigned tmrd,
                                                input logic dll_rst,
                                                input int unsigned dll_wait);
    int unsigned w;
    w = tmrd;
    if (dll_rst && dll_wait > w) w = dll_wait;
    return w;
  endfunction

endpackage

// File: rtl/mrs_down_counter.sv
module mrs_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_CNT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy); // R5

endmodule

// File: rtl/mrs_bank_tracker.sv
module mrs_bank_tracker
  import mrs_guard_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  open_map,
  output logic              all_idle
);
  logic [BANKS-1:0] open_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q[b] <= 1'b0;
      else if (fire) begin
        if (cmd == CMD_PREA)                 open_q[b] <= 1'b0;
        else if (cmd == CMD_PRE && hit)      open_q[b] <= 1'b0;
        else if (cmd == CMD_ACT && hit)      open_q[b] <= 1'b1;
      end
    end
  end

  assign open_map = open_q;
  assign all_idle = ~|open_q;

  AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == CMD_PREA) |=> all_idle); // R3
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == CMD_ACT) |=> !all_idle); // R3

endmodule

// File: rtl/mrs_admit_logic.sv
module mrs_admit_logic
  import mrs_guard_pkg::*;
(
  input  logic req_valid,
  input  cmd_e req_cmd,
  input  logic all_idle,
  input  logic trp_busy,
  input  logic lock_busy,
  output logic ready,
  output logic fire,
  output logic mode_fire,
  output logic pre_fire
);
  logic mode_ok;

  always_comb begin
    mode_ok   = all_idle && !trp_busy;
    ready     = !lock_busy && (!f_is_mode(req_cmd) || mode_ok);
    fire      = req_valid && ready;
    mode_fire = fire && f_is_mode(req_cmd);
    pre_fire  = fire && f_is_precharge(req_cmd);
  end

endmodule

// File: rtl/mrs_timing_guard.sv
module mrs_timing_guard
  import mrs_guard_pkg::*;
#(
  parameter int BANKS       = 8,
  parameter int BANK_W      = 3,
  parameter int MODE_W      = 13,
  parameter int CNT_W       = 8,
  parameter int DLL_BIT     = 8,
  parameter int DLL_WAIT    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_tmrd,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [MODE_W-1:0] req_mode,
  output logic              req_ready,
  output logic [2:0]        bus_cmd,
  output logic [BANK_W-1:0] bus_bank,
  output logic [MODE_W-1:0] bus_mode
);
  localparam int DLL_W  = $clog2(DLL_WAIT + 1);
  localparam int LOCK_W = (CNT_W > DLL_W) ? CNT_W : DLL_W;

  cmd_e             cmd;
  logic             all_idle, trp_busy, lock_busy;
  logic             fire, mode_fire, pre_fire, dll_req;
  logic [BANKS-1:0] open_map;
  logic [CNT_W-1:0] trp_load;
  logic [LOCK_W-1:0] lock_load;

  assign cmd     = cmd_e'(req_cmd);
  assign dll_req = (cmd == CMD_MRS) && req_mode[DLL_BIT];

  assign trp_load  = CNT_W'(f_wait_load(int'(cfg_trp)));
  assign lock_load = LOCK_W'(f_wait_load(
                       f_lock_cycles(int'(cfg_tmrd), dll_req, DLL_WAIT)));

  mrs_bank_tracker #(.BANKS(BANKS), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd), .bank(req_bank),
    .open_map(open_map), .all_idle(all_idle)
  );

  mrs_down_counter #(.W(CNT_W)) u_trp_cnt (
    .clk(clk), .rst_n(rst_n), .load(pre_fire), .load_val(trp_load),
    .busy(trp_busy)
  );

  mrs_down_counter #(.W(LOCK_W)) u_lock_cnt (
    .clk(clk), .rst_n(rst_n), .load(mode_fire), .load_val(lock_load),
    .busy(lock_busy)
  );

  mrs_admit_logic u_admit (
    .req_valid(req_valid), .req_cmd(cmd), .all_idle(all_idle),
    .trp_busy(trp_busy), .lock_busy(lock_busy), .ready(req_ready),
    .fire(fire), .mode_fire(mode_fire), .pre_fire(pre_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cmd  <= CMD_NOP;
      bus_bank <= '0;
      bus_mode <= '0;
    end else if (fire) begin
      bus_cmd  <= req_cmd;
      bus_bank <= req_bank;
      bus_mode <= req_mode;
    end else begin
      bus_cmd  <= CMD_NOP;
      bus_bank <= '0;
      bus_mode <= '0;
    end
  end

  AST_MODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fire |-> (open_map == '0)); // R3
  AST_TRP_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (trp_busy && f_is_mode(cmd)) |-> !req_ready); // R4
  AST_LOCK_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> !req_ready); // R5
  AST_LOCK_BUS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |=> (bus_cmd == CMD_NOP)); // R5
  AST_MODE_STARTS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fire && (dll_req || cfg_tmrd > 1)) |=> lock_busy); // R6
  AST_IDLE_BUS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (bus_cmd == CMD_NOP)); // R9

endmodule

// File: tb/mrs_timing_guard_bench.sv
`timescale 1ns/1ps
module mrs_timing_guard_bench;
  localparam int BANK_W = 3;
  localparam int MODE_W = 13;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cfg_trp = 8'd3;
  logic [CNT_W-1:0]  cfg_tmrd = 8'd2;
  logic              req_valid = 1'b0;
  logic [2:0]        req_cmd = 3'd0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [MODE_W-1:0] req_mode = '0;
  logic              req_ready;
  logic [2:0]        bus_cmd;
  logic [BANK_W-1:0] bus_bank;
  logic [MODE_W-1:0] bus_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mrs_timing_guard u_mrs_timing_guard (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_tmrd(cfg_tmrd),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_mode(req_mode), .req_ready(req_ready), .bus_cmd(bus_cmd),
    .bus_bank(bus_bank), .bus_mode(bus_mode)
  );

  // {valid, cmd, bank, expected ready}; tRP=3, tMRD=2
  localparam int NV = 19;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 3'd1, 3'd1, 1'b1},  // ACT b1             R3
    {1'b1, 3'd6, 3'd0, 1'b0},  // MRS, bank open    R3
    {1'b1, 3'd4, 3'd1, 1'b1},  // PRE b1            R3
    {1'b1, 3'd6, 3'd0, 1'b0},  // tRP running       R4
    {1'b1, 3'd6, 3'd0, 1'b0},  //                   R4
    {1'b1, 3'd6, 3'd0, 1'b1},  // edge k+tRP        R4
    {1'b1, 3'd2, 3'd0, 1'b0},  // tMRD gap          R5
    {1'b1, 3'd7, 3'd0, 1'b1},  // EMRS              R5
    {1'b1, 3'd1, 3'd2, 1'b0},  // gap after EMRS    R5
    {1'b1, 3'd1, 3'd2, 1'b1},  // ACT b2            R3
    {1'b1, 3'd1, 3'd3, 1'b1},  // ACT b3            R3
    {1'b1, 3'd5, 3'd0, 1'b1},  // PREA              R3
    {1'b1, 3'd7, 3'd0, 1'b0},  // tRP after PREA    R4
    {1'b1, 3'd7, 3'd0, 1'b0},  //                   R4
    {1'b1, 3'd7, 3'd0, 1'b1},  // EMRS allowed      R4
    {1'b1, 3'd3, 3'd0, 1'b0},  // WRITE held        R5
    {1'b1, 3'd3, 3'd0, 1'b1},  // WRITE             R2
    {1'b0, 3'd1, 3'd5, 1'b1},  // ACT not valid     R9
    {1'b1, 3'd6, 3'd0, 1'b1}   // still idle        R9
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // offer a command until accepted; returns edges since the last acceptance
  task automatic offer(input logic [2:0] c, input logic [BANK_W-1:0] b,
                       input logic [MODE_W-1:0] m, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_bank = b; req_mode = m;
      n++;
      #2;
      if (req_ready) break;
      if (n > 1000) break;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    #2;
    chk(bus_cmd == 3'd0 && bus_bank == 0 && bus_mode == 0, "R1 reset bus", bus_cmd, 0);
    req_cmd = 3'd6;
    #1;
    chk(req_ready == 1'b1, "R1 mode ready after reset", req_ready, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic exp_fire;
      @(negedge clk);
      req_valid = VEC[i][7];
      req_cmd   = VEC[i][6:4];
      req_bank  = VEC[i][3:1];
      req_mode  = 13'h0;
      #2;
      chk(req_ready == VEC[i][0], $sformatf("R3/R4/R5 ready step %0d", i),
          req_ready, VEC[i][0]);
      exp_fire = VEC[i][7] && VEC[i][0];
      @(posedge clk);
      #2;
      chk(bus_cmd == (exp_fire ? VEC[i][6:4] : 3'd0) &&
          bus_bank == (exp_fire ? VEC[i][3:1] : 3'd0),
          $sformatf("R2 bus step %0d", i), bus_cmd,
          exp_fire ? VEC[i][6:4] : 0);
    end

    // R6: DLL reset, tMRD shorter than the lock wait
    do_reset();
    cfg_tmrd = 8'd4;
    offer(3'd6, 3'd0, 13'h100, n);
    #1;
    chk(bus_cmd == 3'd6 && bus_mode == 13'h100, "R2 mode value on bus", bus_mode, 13'h100);
    offer(3'd1, 3'd0, 13'h0, n);
    chk(n == 200, "R6 DLL wait edges", n, 200);

    // R6: tMRD longer than the DLL wait governs
    do_reset();
    cfg_tmrd = 8'd250;
    offer(3'd6, 3'd0, 13'h100, n);
    offer(3'd2, 3'd0, 13'h0, n);
    chk(n == 250, "R6 longer tMRD governs", n, 250);

    // R7: DLL bit on EMRS ignored
    do_reset();
    cfg_tmrd = 8'd3;
    offer(3'd7, 3'd0, 13'h100, n);
    offer(3'd1, 3'd0, 13'h0, n);
    chk(n == 3, "R7 EMRS DLL bit ignored", n, 3);

    // R5: plain MRS with tMRD 3
    offer(3'd4, 3'd0, 13'h0, n);
    cfg_trp = 8'd1;
    offer(3'd6, 3'd0, 13'h0, n);
    offer(3'd3, 3'd0, 13'h0, n);
    chk(n == 3, "R5 tMRD gap edges", n, 3);

    // R8: zero configuration acts as one
    do_reset();
    cfg_tmrd = 8'd0;
    cfg_trp  = 8'd0;
    offer(3'd6, 3'd0, 13'h0, n);
    offer(3'd5, 3'd0, 13'h0, n);
    chk(n == 1, "R8 tMRD zero as one", n, 1);
    offer(3'd6, 3'd0, 13'h0, n);
    chk(n == 1, "R8 tRP zero as one", n, 1);

    // R4: tRP does not hold other commands
    do_reset();
    cfg_trp = 8'd5;
    offer(3'd5, 3'd0, 13'h0, n);
    offer(3'd1, 3'd4, 13'h0, n);
    chk(n == 1, "R4 ACT not held by tRP", n, 1);
    offer(3'd4, 3'd4, 13'h0, n);
    offer(3'd6, 3'd0, 13'h0, n);
    chk(n == 5, "R4 mode write after tRP", n, 5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule